// File: doc/BRIEF.md
# MII Nibble to 5B Code-Group Transmit Encoder

This block sits on the 100 Mb/s transmit path between the MII and the scrambler. Each clock it takes one transmit nibble with its enable and error qualifiers and produces one 5-bit code group. The code group is registered, so it appears on the clock after the inputs are sampled.

A packet starts when the enable is seen high while the encoder is idle. The first two nibbles of the preamble are dropped and the start delimiter pair goes out in their place. Every later nibble is translated through the 4B5B data table. A nibble that arrives with the error qualifier high is sent as the halt symbol instead. When the enable falls, the encoder sends the end delimiter pair and then idle symbols until the next packet.

In bypass mode there is no framing and no translation. The error input becomes a fifth data bit, and the raw 5-bit value is passed to the output.

Top module: `mii_5b_tx_encoder`

## Requirements
- R1: During reset and on the first clock after it, code_out is IDLE (11111) and code_valid is 1.
- R2: With bypass low and no packet in progress, each clock whose tx_en is low gives IDLE (11111) on the next clock, whatever tx_er and txd hold.
- R3: When tx_en is sampled high in the idle state, the next two code groups are J (11000) and then K (10001). The two nibbles sampled in those clocks are discarded, even if tx_er is high.
- R4: After K, each clock with tx_en high gives the 4B5B data code for txd on the next clock. The codes are 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: In the data phase, a clock with tx_en and tx_er both high gives HALT (00100) in place of the data code.
- R6: The first clock in the data phase with tx_en low gives T (01101). R (00111) follows on the next clock, and then IDLE.
- R7: If tx_en is low in the clock where K is chosen, K is still sent, and T and R follow it.
- R8: With bypass high, the value {tx_er, txd[3:0]} (tx_er as bit 4) appears unchanged on code_out one clock later, and no delimiter is inserted. Leaving bypass returns the encoder to the idle state.
- R9: A tx_en high sampled while T or R is being chosen does not start a packet. If tx_en stays high, J follows directly after R.
- R10: code_valid is 1 on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Nibble present for transmission |
| tx_er | input | 1 | Coding error request, or fifth raw bit in bypass |
| txd | input | 4 | Transmit nibble |
| bypass | input | 1 | Raw 5-bit pass-through mode |
| code_out | output | 5 | Registered 5-bit code group |
| code_valid | output | 1 | Code group strobe, high every clock |

## Verification
The hardest situations to reach from the ports are the enable edges that land inside a delimiter. These are an enable that falls while K is being chosen, and an enable that comes back while T or R is still pending.

The stimulus targets these directly:
- one-clock and two-clock packets;
- packets that drop the enable for exactly one clock;
- a bypass entry in the middle of a packet.

A queue-based reference model predicts every code group. This shows whether nibbles were swallowed or delimiters were lost at those edges.

// File: rtl/tx5b_pkg.sv
package tx5b_pkg;
   localparam logic [4:0] SYM_IDLE = 5'b11111;
   localparam logic [4:0] SYM_J    = 5'b11000;
   localparam logic [4:0] SYM_K    = 5'b10001;
   localparam logic [4:0] SYM_T    = 5'b01101;
   localparam logic [4:0] SYM_R    = 5'b00111;
   localparam logic [4:0] SYM_HALT = 5'b00100;

   typedef enum logic [2:0] {
      PH_IDLE, PH_K, PH_DATA, PH_T, PH_R
   } phase_e;

   typedef enum logic [2:0] {
      SEL_IDLE, SEL_J, SEL_K, SEL_DATA, SEL_T, SEL_R, SEL_RAW
   } sym_sel_e;
endpackage

// File: rtl/tx5b_nibble_map.sv
module tx5b_nibble_map #(
   parameter int NIBBLE_W = 4,
   parameter int CODE_W   = 5,
   parameter bit USE_CASE = 1'b1
) (
   input  logic [NIBBLE_W-1:0] nib,
   output logic [CODE_W-1:0]   sym
);
   localparam int ENTRIES = 1 << NIBBLE_W;

   if (NIBBLE_W != 4 || CODE_W != 5) begin : g_bad_width
      $error("tx5b_nibble_map supports only a 4-bit to 5-bit mapping");
   end

   if (USE_CASE) begin : g_case
      always_comb begin
         unique case (nib)
            4'h0: sym = 5'b11110;
            4'h1: sym = 5'b01001;
            4'h2: sym = 5'b10100;
            4'h3: sym = 5'b10101;
            4'h4: sym = 5'b01010;
            4'h5: sym = 5'b01011;
            4'h6: sym = 5'b01110;
            4'h7: sym = 5'b01111;
            4'h8: sym = 5'b10010;
            4'h9: sym = 5'b10011;
            4'hA: sym = 5'b10110;
            4'hB: sym = 5'b10111;
            4'hC: sym = 5'b11010;
            4'hD: sym = 5'b11011;
            4'hE: sym = 5'b11100;
            default: sym = 5'b11101;
         endcase
      end
   end else begin : g_flat
      localparam logic [ENTRIES*CODE_W-1:0] FLAT = {
         5'b11101, 5'b11100, 5'b11011, 5'b11010,
         5'b10111, 5'b10110, 5'b10011, 5'b10010,
         5'b01111, 5'b01110, 5'b01011, 5'b01010,
         5'b10101, 5'b10100, 5'b01001, 5'b11110};
      assign sym = FLAT[nib*CODE_W +: CODE_W];
   end
endmodule

// File: rtl/tx5b_frame_fsm.sv
module tx5b_frame_fsm
   import tx5b_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tx_en,
   input  logic     bypass,
   output phase_e   cur_phase,
   output sym_sel_e sel
);
   phase_e nxt_phase;

   always_comb begin
      nxt_phase = cur_phase;
      sel       = SEL_IDLE;
      if (bypass) begin
         sel       = SEL_RAW;
         nxt_phase = PH_IDLE;
      end else begin
         unique case (cur_phase)
            PH_IDLE: if (tx_en) begin
               sel       = SEL_J;
               nxt_phase = PH_K;
            end
            PH_K: begin
               sel       = SEL_K;
               nxt_phase = tx_en ? PH_DATA : PH_T;
            end
            PH_DATA: if (tx_en) begin
               sel = SEL_DATA;
            end else begin
               sel       = SEL_T;
               nxt_phase = PH_R;
            end
            PH_T: begin
               sel       = SEL_T;
               nxt_phase = PH_R;
            end
            PH_R: begin
               sel       = SEL_R;
               nxt_phase = PH_IDLE;
            end
            default: nxt_phase = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_phase <= PH_IDLE;
      else        cur_phase <= nxt_phase;
   end
endmodule

// File: rtl/tx5b_sym_out.sv
module tx5b_sym_out
   import tx5b_pkg::*;
#(
   parameter int NIBBLE_W = 4,
   parameter int CODE_W   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  sym_sel_e            sel,
   input  logic                tx_er,
   input  logic [NIBBLE_W-1:0] txd,
   input  logic [CODE_W-1:0]   data_sym,
   output logic [CODE_W-1:0]   code_out
);
   logic [CODE_W-1:0] sym_nxt;

   always_comb begin
      unique case (sel)
         SEL_J:    sym_nxt = SYM_J;
         SEL_K:    sym_nxt = SYM_K;
         SEL_DATA: sym_nxt = tx_er ? SYM_HALT : data_sym;
         SEL_T:    sym_nxt = SYM_T;
         SEL_R:    sym_nxt = SYM_R;
         SEL_RAW:  sym_nxt = {tx_er, txd};
         default:  sym_nxt = SYM_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_out <= SYM_IDLE;
      else        code_out <= sym_nxt;
   end
endmodule

// File: rtl/mii_5b_tx_encoder.sv
module mii_5b_tx_encoder
   import tx5b_pkg::*;
#(
   parameter int NIBBLE_W     = 4,
   parameter bit MAP_USE_CASE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_en,
   input  logic                tx_er,
   input  logic [NIBBLE_W-1:0] txd,
   input  logic                bypass,
   output logic [NIBBLE_W:0]   code_out,
   output logic                code_valid
);
   localparam int CODE_W = NIBBLE_W + 1;

   if (NIBBLE_W != 4) begin : g_bad_nibble
      $error("mii_5b_tx_encoder requires NIBBLE_W == 4");
   end

   phase_e            cur_phase;
   sym_sel_e          sel;
   logic [CODE_W-1:0] data_sym;

   tx5b_frame_fsm i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .bypass    (bypass),
      .cur_phase (cur_phase),
      .sel       (sel)
   );

   tx5b_nibble_map #(
      .NIBBLE_W (NIBBLE_W),
      .CODE_W   (CODE_W),
      .USE_CASE (MAP_USE_CASE)
   ) i_map (
      .nib (txd),
      .sym (data_sym)
   );

   tx5b_sym_out #(
      .NIBBLE_W (NIBBLE_W),
      .CODE_W   (CODE_W)
   ) i_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .tx_er    (tx_er),
      .txd      (txd),
      .data_sym (data_sym),
      .code_out (code_out)
   );

   assign code_valid = 1'b1;
endmodule

// File: rtl/mii_5b_tx_encoder_chk.sv
module mii_5b_tx_encoder_chk
   import tx5b_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tx_en,
   input logic       tx_er,
   input logic [3:0] txd,
   input logic       bypass,
   input logic [4:0] code_out,
   input logic       code_valid
);
   logic [2:0] quiet_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   quiet_cnt <= '0;
      else if (tx_en || bypass)     quiet_cnt <= '0;
      else if (quiet_cnt != 3'd7)   quiet_cnt <= quiet_cnt + 3'd1;
   end

   p_valid_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid);

   p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_cnt >= 3'd4) |-> code_out == SYM_IDLE);

   p_j_then_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(bypass) && !bypass && code_out == SYM_J) |=> code_out == SYM_K);

   p_halt_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(bypass) && code_out == SYM_HALT) |-> $past(tx_en && tx_er));

   p_t_then_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(bypass) && !bypass && code_out == SYM_T) |=> code_out == SYM_R);

   p_bypass_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bypass)) |-> code_out == $past({tx_er, txd}));

   p_after_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(bypass) && !bypass && code_out == SYM_R)
      |=> (code_out == SYM_IDLE || code_out == SYM_J));
endmodule

bind mii_5b_tx_encoder mii_5b_tx_encoder_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_en      (tx_en),
   .tx_er      (tx_er),
   .txd        (txd),
   .bypass     (bypass),
   .code_out   (code_out),
   .code_valid (code_valid)
);

// File: tb/test_mii_5b_tx_encoder.sv
module test_mii_5b_tx_encoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0;
   logic       tx_er = 1'b0;
   logic [3:0] txd = 4'h0;
   logic       bypass = 1'b0;
   logic [4:0] code_out;
   logic       code_valid;

   int    n_checks = 0;
   int    n_errors = 0;
   string tag = "R1";
   bit    armed = 1'b0;
   bit    done = 1'b0;

   logic [4:0] tbl [16];
   logic [4:0] exp_sym = 5'b11111;
   logic [4:0] pend [$];
   bit         in_pkt = 1'b0;

   localparam logic [4:0] E_IDLE = 5'b11111, E_J = 5'b11000, E_K = 5'b10001,
                          E_T = 5'b01101, E_R = 5'b00111, E_HALT = 5'b00100;

   always #10 clk = ~clk;

   mii_5b_tx_encoder i_mii_5b_tx_encoder (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
      .bypass(bypass), .code_out(code_out), .code_valid(code_valid));

   initial begin
      tbl = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
              5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
              5'b11010, 5'b11011, 5'b11100, 5'b11101};
   end

   // Reference model: predicts the code group registered at this edge
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_sym = E_IDLE; pend.delete(); in_pkt = 1'b0;
      end else if (bypass) begin
         exp_sym = {tx_er, txd}; pend.delete(); in_pkt = 1'b0;
      end else if (pend.size() > 0) begin
         exp_sym = pend.pop_front();
         if (exp_sym == E_K) begin
            if (tx_en) in_pkt = 1'b1;
            else begin pend.push_back(E_T); pend.push_back(E_R); end
         end
      end else if (in_pkt) begin
         if (tx_en) exp_sym = tx_er ? E_HALT : tbl[txd];
         else begin exp_sym = E_T; pend.push_back(E_R); in_pkt = 1'b0; end
      end else if (tx_en) begin
         exp_sym = E_J; pend.push_back(E_K);
      end else begin
         exp_sym = E_IDLE;
      end
   end

   task automatic compare();
      n_checks++;
      if (code_out !== exp_sym) begin
         n_errors++;
         $display("FAIL %s: code_out=%b expected=%b at %0t", tag, code_out, exp_sym, $time);
      end
      n_checks++;
      if (code_valid !== 1'b1) begin
         n_errors++;
         $display("FAIL R10: code_valid=%b expected=1", code_valid);
      end
   endtask

   task automatic step(input logic en, input logic er, input logic [3:0] d, input logic byp);
      @(negedge clk);
      if (armed) compare();
      tx_en = en; tx_er = er; txd = d; bypass = byp;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      n_checks++;
      if (code_out !== E_IDLE || code_valid !== 1'b1) begin
         n_errors++;
         $display("FAIL R1: code_out=%b valid=%b expected=11111/1", code_out, code_valid);
      end
      rst_n = 1'b1;
      armed = 1'b1;
      tag = "R1";
      step(0, 0, 4'h0, 0);
      tag = "R2";
      for (int i = 0; i < 6; i++) step(0, i[0], 4'(i * 3), 0);
      // R3 R4 R6: full packet walking every nibble
      tag = "R3_R4_R6";
      step(1, 1, 4'h5, 0);
      step(1, 0, 4'h5, 0);
      for (int i = 0; i < 16; i++) step(1, 0, 4'(i), 0);
      for (int i = 0; i < 5; i++) step(0, 0, 4'h0, 0);
      // R5: halt in data phase
      tag = "R5";
      step(1, 0, 4'h5, 0);
      step(1, 0, 4'h5, 0);
      step(1, 0, 4'hD, 0);
      step(1, 1, 4'h3, 0);
      step(1, 1, 4'h7, 0);
      step(1, 0, 4'h9, 0);
      for (int i = 0; i < 4; i++) step(0, 1, 4'hF, 0);
      // R7: one-clock and two-clock packets
      tag = "R7";
      step(1, 0, 4'h5, 0);
      for (int i = 0; i < 5; i++) step(0, 0, 4'h0, 0);
      step(1, 0, 4'h5, 0);
      step(1, 0, 4'h5, 0);
      for (int i = 0; i < 5; i++) step(0, 0, 4'h0, 0);
      // R9: re-enable during end delimiter
      tag = "R9";
      step(1, 0, 4'h5, 0);
      step(1, 0, 4'h5, 0);
      step(1, 0, 4'hA, 0);
      step(0, 0, 4'h0, 0);
      for (int i = 0; i < 5; i++) step(1, 0, 4'(i + 1), 0);
      step(0, 0, 4'h0, 0);
      step(1, 0, 4'hC, 0);
      step(0, 0, 4'h0, 0);
      for (int i = 0; i < 5; i++) step(0, 0, 4'h0, 0);
      // R8: bypass including values that look like delimiters
      tag = "R8";
      step(1, 1, 4'h8, 1);
      step(0, 1, 4'h1, 1);
      step(1, 0, 4'hD, 1);
      for (int i = 0; i < 32; i++) step(i[1], i[4], 4'(i), 1);
      step(0, 0, 4'h0, 0);
      step(0, 0, 4'h0, 0);
      // R8: bypass entered mid-packet, then a clean packet
      step(1, 0, 4'h5, 0);
      step(1, 0, 4'h5, 0);
      step(1, 0, 4'h2, 0);
      step(1, 0, 4'h6, 1);
      step(0, 0, 4'h0, 0);
      step(1, 0, 4'h5, 0);
      step(1, 0, 4'h5, 0);
      step(1, 0, 4'hB, 0);
      tag = "R6";
      for (int i = 0; i < 5; i++) step(0, 0, 4'h0, 0);
      tag = "R2";
      for (int i = 0; i < 4; i++) step(0, 1, 4'(i), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule